// File: doc/BRIEF.md
# Two-Level Latched Interrupt Aggregator

The block collects single-cycle event pulses from eight 8-bit status sources and holds each one in a sticky latched status bit. Every latched register has its own per-bit enable register. The enables decide which latched bits count toward an interrupt. They never decide which bits get recorded, so the host can also poll conditions that it keeps out of the interrupt path.

Enabled latched bits are ORed into four live group status bits:
- Group 0 collects registers 0 and 1.
- Group 1 collects registers 2 to 5.
- Group 2 collects register 6.
- Group 3 collects register 7.

A group enable register gates each group onto one active-low interrupt pin. A small two-state machine drives that pin. When the pin is idle it is either released (output enable low, an external pull-up holds the line) or actively driven high, as a control bit selects.

A host reaches every register through a simple synchronous strobe bus with a 5-bit address. Writing a 1 clears a latched bit. Reading a latched register returns its contents and clears the whole register. An event always beats a clear that lands on the same bit in the same cycle.

Top module: `irq_agg`

## Requirements
- R1: A high cycle on `evt_i[8*i+b]` sets bit b of latched register i on that clock edge. The bit then stays set until it is cleared, and it is readable from the following cycle.
- R2: Latched register i sits at address i (0x00 to 0x07). Writing it clears each bit whose write-data bit is 1 and leaves each bit whose write-data bit is 0 unchanged.
- R3: A read strobe returns the addressed register on `bus_rdata_o` in the cycle after the strobe edge. A read of a latched register clears all of its bits on that edge.
- R4: When an event and a clear (write-one or read) hit the same latched bit in the same cycle, the bit ends up set.
- R5: The bit-enable register for latched register i sits at address 0x08+i. An enable bit of 0 keeps the latched bit out of the group status, but the latched bit is still set by its event.
- R6: The group status at address 0x10 is read-only, and writes to it have no effect. Its bit g is the live OR of (latched AND enable) over the registers mapped to group g (registers 0-1 to group 0, registers 2-5 to group 1, register 6 to group 2, register 7 to group 3). The bit falls by itself once no enabled latched bit remains.
- R7: The group enable register sits at address 0x11 (bit g for group g). One cycle after any (group status AND group enable) bit is 1, the pin is asserted (`irq_oe_o`=1, `irq_n_o`=0). One cycle after none is 1, the pin is deasserted.
- R8: Control register 0x12 bit 0 selects the idle drive. With 0 (the reset value), the idle pin is released (`irq_oe_o`=0, `irq_n_o`=1). With 1, the idle pin is driven high (`irq_oe_o`=1, `irq_n_o`=1).
- R9: While `rst_ni` is low the pin is never asserted and events are not recorded. After reset, every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 64 | Event pulses, bit 8*i+b feeds latched register i bit b |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | 5 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid the cycle after a read strobe |
| irq_n_o | output | 1 | Interrupt pin data, active low |
| irq_oe_o | output | 1 | Interrupt pin output enable |

## Verification
The timing of each result is as follows:
- An event or a bus write changes register state on the edge where it is sampled.
- The group status follows combinationally.
- The pin moves one edge later, so it changes two edges after an event.
- Read data appears after the strobe edge.

The bench drives every stimulus on a falling edge and samples on the next falling edge. For each pin check it waits exactly the number of edges counted above. It also checks the cycle before the pin changes, so that an early or late pin is caught as well as a wrong one.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int unsigned LAT_REGS = 8;
    localparam int unsigned REG_W    = 8;
    localparam int unsigned GROUPS   = 4;
    localparam int unsigned ADDR_W   = 5;

    localparam logic [ADDR_W-1:0] A_ENA_BASE = 5'h08;
    localparam logic [ADDR_W-1:0] A_GSTAT    = 5'h10;
    localparam logic [ADDR_W-1:0] A_GENA     = 5'h11;
    localparam logic [ADDR_W-1:0] A_CTRL     = 5'h12;

    typedef enum logic [0:0] {
        PIN_IDLE   = 1'b0,
        PIN_ASSERT = 1'b1
    } pin_state_e;

    // Which group a latched register feeds: 0-1 -> 0, 2-5 -> 1, then one each.
    function automatic int group_of(input int r);
        if (r < 2)      return 0;
        else if (r < 6) return 1;
        else            return r - 4;
    endfunction

endpackage

// File: rtl/irq_latch_bank.sv
module irq_latch_bank
    import irq_agg_pkg::*;
#(
    parameter int unsigned NREG = LAT_REGS,
    parameter int unsigned W    = REG_W
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NREG*W-1:0]   evt_i,
    input  logic                wr_i,
    input  logic                rd_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [W-1:0]        wdata_i,
    output logic [NREG*W-1:0]   lat_o,
    output logic [NREG*W-1:0]   ena_o
);

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        localparam logic [ADDR_W-1:0] LAT_ADDR = ADDR_W'(r);
        localparam logic [ADDR_W-1:0] ENA_ADDR = A_ENA_BASE + ADDR_W'(r);

        logic [W-1:0] clr_mask;
        logic [W-1:0] lat_q;
        logic [W-1:0] ena_q;

        always_comb begin
            clr_mask = '0;
            if (addr_i == LAT_ADDR) begin
                if (wr_i)      clr_mask = wdata_i;
                else if (rd_i) clr_mask = '1;
            end
        end

        // set wins: OR in the event after the clear
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) lat_q <= '0;
            else         lat_q <= (lat_q & ~clr_mask) | evt_i[r*W +: W];
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)                           ena_q <= '0;
            else if (wr_i && addr_i == ENA_ADDR)   ena_q <= wdata_i;
        end

        assign lat_o[r*W +: W] = lat_q;
        assign ena_o[r*W +: W] = ena_q;
    end

endmodule

// File: rtl/irq_group_merge.sv
module irq_group_merge
    import irq_agg_pkg::*;
#(
    parameter int unsigned NREG = LAT_REGS,
    parameter int unsigned W    = REG_W,
    parameter int unsigned NGRP = GROUPS
) (
    input  logic [NREG*W-1:0] lat_i,
    input  logic [NREG*W-1:0] ena_i,
    output logic [NGRP-1:0]   grp_o
);

    logic [NREG-1:0] reg_hit;

    always_comb begin
        for (int r = 0; r < NREG; r++) begin
            reg_hit[r] = |(lat_i[r*W +: W] & ena_i[r*W +: W]);
        end
    end

    always_comb begin
        grp_o = '0;
        for (int g = 0; g < int'(NGRP); g++) begin
            for (int r = 0; r < int'(NREG); r++) begin
                if (group_of(r) == g) grp_o[g] = grp_o[g] | reg_hit[r];
            end
        end
    end

endmodule

// File: rtl/irq_pin_fsm.sv
module irq_pin_fsm
    import irq_agg_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic req_i,
    input  logic drive_idle_i,
    output logic irq_n_o,
    output logic irq_oe_o
);

    pin_state_e state_q;
    pin_state_e state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= PIN_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PIN_IDLE:   if (req_i)  state_d = PIN_ASSERT;
            PIN_ASSERT: if (!req_i) state_d = PIN_IDLE;
            default:                state_d = PIN_IDLE;
        endcase
    end

    always_comb begin
        irq_n_o  = 1'b1;
        irq_oe_o = drive_idle_i;
        unique case (state_q)
            PIN_IDLE: begin
                irq_n_o  = 1'b1;
                irq_oe_o = drive_idle_i;
            end
            PIN_ASSERT: begin
                irq_n_o  = 1'b0;
                irq_oe_o = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/irq_agg.sv
module irq_agg
    import irq_agg_pkg::*;
#(
    parameter int unsigned NREG = LAT_REGS,
    parameter int unsigned W    = REG_W,
    parameter int unsigned NGRP = GROUPS
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NREG*W-1:0]   evt_i,
    input  logic                bus_wr_i,
    input  logic                bus_rd_i,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    input  logic [W-1:0]        bus_wdata_i,
    output logic [W-1:0]        bus_rdata_o,
    output logic                irq_n_o,
    output logic                irq_oe_o
);

    logic [NREG*W-1:0] lat_q;
    logic [NREG*W-1:0] ena_q;
    logic [NGRP-1:0]   grp_stat;
    logic [NGRP-1:0]   grp_en_q;
    logic              drive_idle_q;
    logic              irq_req;
    logic [W-1:0]      rd_next;

    irq_latch_bank #(.NREG(NREG), .W(W)) u_bank (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .evt_i   (evt_i),
        .wr_i    (bus_wr_i),
        .rd_i    (bus_rd_i),
        .addr_i  (bus_addr_i),
        .wdata_i (bus_wdata_i),
        .lat_o   (lat_q),
        .ena_o   (ena_q)
    );

    irq_group_merge #(.NREG(NREG), .W(W), .NGRP(NGRP)) u_merge (
        .lat_i (lat_q),
        .ena_i (ena_q),
        .grp_o (grp_stat)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            grp_en_q     <= '0;
            drive_idle_q <= 1'b0;
        end else if (bus_wr_i) begin
            if (bus_addr_i == A_GENA) grp_en_q     <= bus_wdata_i[NGRP-1:0];
            if (bus_addr_i == A_CTRL) drive_idle_q <= bus_wdata_i[0];
        end
    end

    assign irq_req = |(grp_stat & grp_en_q);

    irq_pin_fsm u_pin (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .req_i        (irq_req),
        .drive_idle_i (drive_idle_q),
        .irq_n_o      (irq_n_o),
        .irq_oe_o     (irq_oe_o)
    );

    always_comb begin
        rd_next = '0;
        for (int r = 0; r < int'(NREG); r++) begin
            if (bus_addr_i == ADDR_W'(r))              rd_next = lat_q[r*W +: W];
            if (bus_addr_i == A_ENA_BASE + ADDR_W'(r)) rd_next = ena_q[r*W +: W];
        end
        if (bus_addr_i == A_GSTAT) rd_next = W'(grp_stat);
        if (bus_addr_i == A_GENA)  rd_next = W'(grp_en_q);
        if (bus_addr_i == A_CTRL)  rd_next = W'(drive_idle_q);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       bus_rdata_o <= '0;
        else if (bus_rd_i) bus_rdata_o <= rd_next;
    end

endmodule

// File: rtl/irq_agg_checker.sv
module irq_agg_checker
    import irq_agg_pkg::*;
#(
    parameter int unsigned NREG = LAT_REGS,
    parameter int unsigned W    = REG_W
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [NREG*W-1:0] evt_i,
    input logic              bus_wr_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [W-1:0]      bus_wdata_i,
    input logic [NREG*W-1:0] lat_q,
    input logic              irq_req,
    input logic              irq_n_o,
    input logic              irq_oe_o
);

    logic [NREG*W-1:0] wr_mask;

    always_comb begin
        wr_mask = '0;
        for (int r = 0; r < int'(NREG); r++) begin
            if (bus_wr_i && bus_addr_i == ADDR_W'(r)) wr_mask[r*W +: W] = bus_wdata_i;
        end
    end

    assert_latch_capture_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((lat_q & $past(evt_i)) == $past(evt_i)));

    assert_w1c_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|wr_mask) |=> ((lat_q & $past(wr_mask) & ~$past(evt_i)) == '0));

    assert_pin_asserts_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_req |=> (!irq_n_o && irq_oe_o));

    assert_pin_releases_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !irq_req |=> irq_n_o);

    assert_released_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !irq_oe_o |-> irq_n_o);

    assert_quiet_in_reset_R9: assert property (@(posedge clk_i)
        !rst_ni |-> irq_n_o);

endmodule

bind irq_agg irq_agg_checker #(.NREG(NREG), .W(W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_i       (evt_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .lat_q       (lat_q),
    .irq_req     (irq_req),
    .irq_n_o     (irq_n_o),
    .irq_oe_o    (irq_oe_o)
);

// File: tb/tb_irq_agg.sv
module tb_irq_agg;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] evt = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [4:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        irq_n;
    logic        irq_oe;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_agg dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .evt_i       (evt),
        .bus_wr_i    (wr),
        .bus_rd_i    (rd),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_n_o     (irq_n),
        .irq_oe_o    (irq_oe)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk); rd = 1'b1; addr = a;
        @(negedge clk); rd = 1'b0; d = rdata;
    endtask

    task automatic pulse(input int r, input int b);
        @(negedge clk); evt[r*8+b] = 1'b1;
        @(negedge clk); evt = '0;
    endtask

    task automatic cycle();
        @(negedge clk);
    endtask

    function automatic int pin_state();
        return {irq_oe, irq_n};
    endfunction

    task automatic t_reset_values();
        logic [7:0] d;
        chk("R9 pin idle after reset {oe,n}", pin_state(), 2'b01);
        bus_read(5'h00, d); chk("R9 latched reg0 reset", d, 0);
        bus_read(5'h08, d); chk("R9 enable reg0 reset", d, 0);
        bus_read(5'h10, d); chk("R9 group status reset", d, 0);
        bus_read(5'h11, d); chk("R9 group enable reset", d, 0);
        bus_read(5'h12, d); chk("R9 control reset", d, 0);
    endtask

    task automatic t_latch_w1c();
        logic [7:0] d;
        pulse(2, 3);
        pulse(2, 5);
        bus_write(5'h02, 8'h00);
        bus_write(5'h02, 8'h08);
        bus_read(5'h02, d);  chk("R1 R2 write-one clears only bit3", d, 8'h20);
        bus_read(5'h02, d);  chk("R3 read cleared register", d, 0);
    endtask

    task automatic t_mask_poll();
        logic [7:0] d;
        pulse(4, 0);
        bus_read(5'h10, d);  chk("R5 disabled bit kept out of group", d, 0);
        chk("R5 pin idle with disabled bit", pin_state(), 2'b01);
        bus_read(5'h04, d);  chk("R5 disabled bit still latched", d, 8'h01);
    endtask

    task automatic t_group_agg();
        logic [7:0] d;
        bus_write(5'h08, 8'h02);
        bus_write(5'h0D, 8'hFF);
        bus_write(5'h0B, 8'h10);
        pulse(0, 1);
        bus_read(5'h10, d);  chk("R6 reg0 feeds group0", d, 8'h01);
        pulse(5, 7);
        bus_read(5'h10, d);  chk("R6 reg5 feeds group1", d, 8'h03);
        bus_write(5'h10, 8'h00);
        bus_read(5'h10, d);  chk("R6 write to group status ignored", d, 8'h03);
        bus_write(5'h00, 8'h02);
        bus_read(5'h10, d);  chk("R6 group0 falls after clear", d, 8'h02);
        bus_read(5'h05, d);  chk("R3 read returns reg5", d, 8'h80);
        bus_read(5'h10, d);  chk("R6 group1 falls after read clear", d, 8'h00);
        pulse(3, 4);
        bus_read(5'h10, d);  chk("R6 reg3 feeds group1", d, 8'h02);
        bus_read(5'h03, d);
        bus_write(5'h0B, 8'h00);
        bus_write(5'h08, 8'h00);
        bus_write(5'h0D, 8'h00);
    endtask

    task automatic t_pin();
        logic [7:0] d;
        bus_write(5'h11, 8'h0F);
        bus_write(5'h0E, 8'h01);
        pulse(6, 0);
        chk("R7 pin not yet asserted (latency)", pin_state(), 2'b01);
        cycle();
        chk("R7 pin asserted", pin_state(), 2'b10);
        bus_write(5'h11, 8'h0B);
        chk("R7 pin still asserted on gate edge", pin_state(), 2'b10);
        cycle();
        chk("R7 group enable blocks pin", pin_state(), 2'b01);
        bus_write(5'h11, 8'h0F);
        cycle();
        chk("R7 pin re-asserted", pin_state(), 2'b10);
        bus_read(5'h06, d);
        chk("R3 read reg6 value", d, 8'h01);
        cycle();
        chk("R7 pin released after read clear", pin_state(), 2'b01);
    endtask

    task automatic t_drive();
        bus_write(5'h12, 8'h01);
        chk("R8 idle actively driven high", pin_state(), 2'b11);
        bus_write(5'h12, 8'h00);
        chk("R8 idle released", pin_state(), 2'b01);
    endtask

    task automatic t_collision();
        logic [7:0] d;
        pulse(7, 2);
        @(negedge clk); wr = 1'b1; addr = 5'h07; wdata = 8'h04; evt[7*8+2] = 1'b1;
        @(negedge clk); wr = 1'b0; evt = '0;
        bus_read(5'h07, d);  chk("R4 event wins over write-one", d, 8'h04);
        pulse(7, 2);
        @(negedge clk); rd = 1'b1; addr = 5'h07; evt[7*8+6] = 1'b1;
        @(negedge clk); rd = 1'b0; evt = '0; d = rdata;
        chk("R3 read shows prior contents", d, 8'h04);
        bus_read(5'h07, d);  chk("R4 event wins over read clear", d, 8'h40);
    endtask

    task automatic t_reset_suppress();
        logic [7:0] d;
        bus_write(5'h0E, 8'h01);
        pulse(6, 0);
        cycle();
        chk("R7 pin asserted before reset", pin_state(), 2'b10);
        @(negedge clk); rst_n = 1'b0;
        #1;
        chk("R9 pin dropped in reset", pin_state(), 2'b01);
        @(negedge clk); evt[6*8+0] = 1'b1;
        @(negedge clk);
        chk("R9 pin quiet with event in reset", pin_state(), 2'b01);
        evt = '0;
        @(negedge clk); rst_n = 1'b1;
        bus_read(5'h06, d);  chk("R9 event in reset not latched", d, 0);
        chk("R9 pin idle after reset release", pin_state(), 2'b01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_values();
        t_latch_w1c();
        t_mask_poll();
        t_group_agg();
        t_pin();
        t_drive();
        t_collision();
        t_reset_suppress();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule